// File: doc/BRIEF.md
# Vectored Nested Interrupt Controller

This block gathers 32 interrupt sources and steers each one to either a fast interrupt line (`fiq_o`) or a normal interrupt line (`irq_o`). A source is pending when its hardware request line is high or software has set its soft bit. Each source has an enable bit and a route bit. Normal interrupts go through sixteen programmable vector slots. Each slot has a fixed priority, with slot 0 the most urgent, and binds one source to a service address. Any enabled normal source that no slot claims is served at a seventeenth, unvectored level, and that level has its own default address.

Software starts service by reading the vector register. That read returns the address of the most urgent pending level above the one now in service. The controller then moves to that level and keeps the level it left. Software ends service by writing the vector register with any value, which brings back the level that was kept. While a level is in service, `irq_o` only reports sources bound to more urgent slots. Nested preemption is therefore handled by the controller and not by software. The register bus is a plain single-cycle word-addressed port. It has no handshake, because every access completes in one cycle. Read data is registered and appears on the cycle after the read strobe.

Top module: `vec_intc`

## Requirements
- R1: A source is raw-pending when `hw_req[s]` or its soft bit is set. Word 2 reads the raw vector. Word 0 reads the raw vector ANDed with the enables and with the inverted route bits. Word 1 reads the raw vector ANDed with the route bits.
- R2: `fiq_o` is high exactly when word 1 is nonzero. The enables and the service level have no effect on it.
- R3: Word 3 is the route register, where bit value 1 means fast. Writing word 4 sets enables wherever a data bit is 1, and writing word 5 clears them. Reading word 4 returns the enables. Words 6 and 7 set and clear the soft bits in the same way, and reading word 6 returns them.
- R4: Slot n (0..15) has its address register at word 0x40+n and its control register at word 0x80+n. Control bit 5 enables the slot and bits 4:0 name the source. Both registers read back what was written, with the control register limited to 6 bits. Word 13 holds the default address.
- R5: Reset sets all slot addresses, slot controls, the default address, enables, routes and soft bits to zero. It also sets the service level to idle (17).
- R6: `irq_o` is high when some word-0 source is a member of the current level's mask. The mask of level L holds the sources of the enabled slots numbered below L. Level 16 covers every enabled slot, and the idle level covers all sources.
- R7: A read of word 12 finds the most urgent level below the current one that has a word-0 source in the mask of the next level. It returns that slot's address, or the default address for level 16. It makes that level current and keeps the old level for it.
- R8: A read of word 12 when no such level exists returns the default address and leaves the level unchanged. A source that is disabled or routed fast cannot raise the level.
- R9: A write to word 12 ignores the data. It returns the level to the value kept for the current level. At idle it has no effect.
- R10: Words 0x3F8 to 0x3FF read the bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, in that order.
- R11: Writes to word 0 and to undefined words have no effect. Undefined words read zero. Word 8 keeps only bit 0 of the written data.
- R12: `reg_rdata` takes the read value on the edge where `reg_re` is high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | 32 | Hardware request level per source |
| reg_addr | input | 10 | Word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A corrupted service level or kept-level entry shows at `irq_o` in the same cycle: a level that is too urgent hides pending work, and a level that is not urgent enough lets lower slots preempt. It also shows on the next vector read, which returns the wrong address. A wrong mask bit shows only once a source of that slot is pending while a less urgent level is in service. For that reason the bench builds nesting chains several levels deep and unwinds them one step at a time.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  localparam int unsigned WI_IRQ_STAT = 0;
  localparam int unsigned WI_FIQ_STAT = 1;
  localparam int unsigned WI_RAW      = 2;
  localparam int unsigned WI_ROUTE    = 3;
  localparam int unsigned WI_EN_SET   = 4;
  localparam int unsigned WI_EN_CLR   = 5;
  localparam int unsigned WI_SOFT_SET = 6;
  localparam int unsigned WI_SOFT_CLR = 7;
  localparam int unsigned WI_LOCK     = 8;
  localparam int unsigned WI_VEC      = 12;
  localparam int unsigned WI_DEFADDR  = 13;
  localparam int unsigned WI_SLOT_VA  = 64;
  localparam int unsigned WI_SLOT_CT  = 128;
  localparam int unsigned WI_IDENT    = 1016;

  function automatic logic [7:0] ident_byte(input logic [2:0] k);
    case (k)
      3'd0: return 8'h90;
      3'd1: return 8'h11;
      3'd2: return 8'h04;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/vec_intc_src_regs.sv
module vec_intc_src_regs #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned AW   = 10,
  parameter int unsigned DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] hw_req,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] irq_stat,
  output logic [NSRC-1:0] fiq_stat,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] route_q,
  output logic [NSRC-1:0] soft_q,
  output logic            lock_q
);
  import vec_intc_pkg::*;

  logic [NSRC-1:0] wbits;
  assign wbits = wdata[NSRC-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      soft_q  <= '0;
      lock_q  <= 1'b0;
    end else if (we) begin
      case (int'(addr))
        WI_ROUTE:    route_q <= wbits;
        WI_EN_SET:   en_q    <= en_q | wbits;
        WI_EN_CLR:   en_q    <= en_q & ~wbits;
        WI_SOFT_SET: soft_q  <= soft_q | wbits;
        WI_SOFT_CLR: soft_q  <= soft_q & ~wbits;
        WI_LOCK:     lock_q  <= wdata[0];
        default: ;
      endcase
    end
  end

  assign raw      = hw_req | soft_q;
  assign irq_stat = raw & en_q & ~route_q;
  assign fiq_stat = raw & route_q;

  // R3: set/clear words only ever add or remove the flagged bits
  p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) == WI_EN_SET) |=> ((en_q & $past(wbits)) == $past(wbits)));
  p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) == WI_EN_CLR) |=> ((en_q & $past(wbits)) == '0));
endmodule

// File: rtl/vec_intc_slots.sv
module vec_intc_slots #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 16,
  parameter int unsigned AW    = 10,
  parameter int unsigned DW    = 32,
  localparam int unsigned SW   = $clog2(NSRC),
  localparam int unsigned CW   = SW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   vaddr [NSLOT+1],
  output logic [CW-1:0]   vctl  [NSLOT],
  output logic [NSRC-1:0] mask  [NSLOT+2]
);
  import vec_intc_pkg::*;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vaddr[g] <= '0;
        vctl[g]  <= '0;
      end else if (we) begin
        if (int'(addr) == WI_SLOT_VA + g) vaddr[g] <= wdata;
        if (int'(addr) == WI_SLOT_CT + g) vctl[g]  <= wdata[CW-1:0];
      end
    end
    assign mask[g+1] = mask[g] |
      (vctl[g][SW] ? (NSRC'(1) << vctl[g][SW-1:0]) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vaddr[NSLOT] <= '0;
    else if (we && int'(addr) == WI_DEFADDR) vaddr[NSLOT] <= wdata;
  end

  assign mask[0]       = '0;
  assign mask[NSLOT+1] = '1;
endmodule

// File: rtl/vec_intc_level.sv
module vec_intc_level #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 16,
  localparam int unsigned IDLE = NSLOT + 1,
  localparam int unsigned LW   = $clog2(NSLOT + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack,
  input  logic            eoi,
  input  logic [NSRC-1:0] irq_stat,
  input  logic [NSRC-1:0] mask [NSLOT+2],
  output logic [LW-1:0]   cur,
  output logic            hit,
  output logic [LW-1:0]   hit_lvl
);
  logic [LW-1:0]  kept [NSLOT+1];
  logic [NSLOT:0] pend;
  logic [LW-1:0]  kept_cur;

  for (genvar g = 0; g <= NSLOT; g++) begin : g_pend
    assign pend[g] = |(irq_stat & mask[g+1]);
  end

  always_comb begin
    hit     = 1'b0;
    hit_lvl = cur;
    for (int i = NSLOT; i >= 0; i--) begin
      if (pend[i] && LW'(i) < cur) begin
        hit     = 1'b1;
        hit_lvl = LW'(i);
      end
    end
  end

  always_comb begin
    kept_cur = LW'(IDLE);
    for (int i = 0; i <= NSLOT; i++)
      if (cur == LW'(i)) kept_cur = kept[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= LW'(IDLE);
      for (int i = 0; i <= NSLOT; i++) kept[i] <= LW'(IDLE);
    end else if (ack && hit) begin
      cur <= hit_lvl;
      for (int i = 0; i <= NSLOT; i++)
        if (hit_lvl == LW'(i)) kept[i] <= cur;
    end else if (eoi && cur < LW'(IDLE)) begin
      cur <= kept_cur;
    end
  end

  p_level_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cur <= LW'(IDLE));
  p_ack_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && hit) |=> (cur == $past(hit_lvl) && cur < $past(cur)));
  p_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> $stable(cur));
  p_eoi_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && cur < LW'(IDLE)) |=> (cur == $past(kept_cur) && cur > $past(cur)));
  p_idle_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && cur == LW'(IDLE)) |=> cur == LW'(IDLE));
endmodule

// File: rtl/vec_intc.sv
module vec_intc #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 16,
  parameter int unsigned AW    = 10,
  parameter int unsigned DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC-1:0] hw_req,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_re,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o,
  output logic          fiq_o
);
  import vec_intc_pkg::*;

  localparam int unsigned SW   = $clog2(NSRC);
  localparam int unsigned CW   = SW + 1;
  localparam int unsigned IDLE = NSLOT + 1;
  localparam int unsigned LW   = $clog2(NSLOT + 2);

  logic [NSRC-1:0] raw, irq_stat, fiq_stat, en_q, route_q, soft_q;
  logic            lock_q;
  logic [DW-1:0]   vaddr [NSLOT+1];
  logic [CW-1:0]   vctl  [NSLOT];
  logic [NSRC-1:0] mask  [NSLOT+2];
  logic [LW-1:0]   cur, hit_lvl;
  logic            hit, ack, eoi;
  logic [NSRC-1:0] cur_mask;
  logic [DW-1:0]   rd_val, vec_val;

  assign ack = reg_re && !reg_we && int'(reg_addr) == WI_VEC;
  assign eoi = reg_we && int'(reg_addr) == WI_VEC;

  vec_intc_src_regs #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_src (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .hw_req(hw_req), .raw(raw), .irq_stat(irq_stat), .fiq_stat(fiq_stat),
    .en_q(en_q), .route_q(route_q), .soft_q(soft_q), .lock_q(lock_q)
  );

  vec_intc_slots #(.NSRC(NSRC), .NSLOT(NSLOT), .AW(AW), .DW(DW)) u_slots (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .vaddr(vaddr), .vctl(vctl), .mask(mask)
  );

  vec_intc_level #(.NSRC(NSRC), .NSLOT(NSLOT)) u_level (
    .clk(clk), .rst_n(rst_n), .ack(ack), .eoi(eoi), .irq_stat(irq_stat),
    .mask(mask), .cur(cur), .hit(hit), .hit_lvl(hit_lvl)
  );

  always_comb begin
    cur_mask = '1;
    for (int i = 0; i <= NSLOT; i++)
      if (cur == LW'(i)) cur_mask = mask[i];
  end

  assign irq_o = |(irq_stat & cur_mask);
  assign fiq_o = |fiq_stat;

  always_comb begin
    vec_val = vaddr[NSLOT];
    if (hit)
      for (int i = 0; i < NSLOT; i++)
        if (hit_lvl == LW'(i)) vec_val = vaddr[i];
  end

  always_comb begin
    rd_val = '0;
    case (int'(reg_addr))
      WI_IRQ_STAT: rd_val = DW'(irq_stat);
      WI_FIQ_STAT: rd_val = DW'(fiq_stat);
      WI_RAW:      rd_val = DW'(raw);
      WI_ROUTE:    rd_val = DW'(route_q);
      WI_EN_SET:   rd_val = DW'(en_q);
      WI_SOFT_SET: rd_val = DW'(soft_q);
      WI_LOCK:     rd_val = DW'(lock_q);
      WI_VEC:      rd_val = vec_val;
      WI_DEFADDR:  rd_val = vaddr[NSLOT];
      default: begin
        for (int i = 0; i < NSLOT; i++) begin
          if (int'(reg_addr) == WI_SLOT_VA + i) rd_val = vaddr[i];
          if (int'(reg_addr) == WI_SLOT_CT + i) rd_val = DW'(vctl[i]);
        end
        if (int'(reg_addr) >= WI_IDENT && int'(reg_addr) < WI_IDENT + 8)
          rd_val = DW'(ident_byte(reg_addr[2:0]));
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_val;
  end

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == '0) |-> (!irq_o && !fiq_o));
  p_idle_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == LW'(IDLE) && irq_stat != '0) |-> irq_o);
  p_top_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == '0) |-> !irq_o);
  p_fiq_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & route_q) != '0) |-> fiq_o);
  p_ident_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && int'(reg_addr) == WI_IDENT) |=> reg_rdata == DW'(8'h90));
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |=> $stable(reg_rdata));
endmodule

// File: tb/vec_intc_tb.sv
module vec_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] hw_req = '0;
  logic [9:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_re = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  localparam logic [31:0] DEFA = 32'h0000_DEF0;

  always #5 clk = ~clk;

  vec_intc u_dut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [31:0] slot_addr(input int n);
    return 32'h8000_0000 + 32'(n) * 32'h10;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = 10'(a); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 10'(a); reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, all requirements affected");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] idb [8];
    idb = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R5 reset state
    chk("R5 irq_o", 32'(irq_o), 0);
    chk("R5 fiq_o", 32'(fiq_o), 0);
    rd(13, rv); chk("R5 default addr", rv, 0);
    rd(4, rv);  chk("R5 enables", rv, 0);
    for (int n = 0; n < 16; n++) begin
      rd(64 + n, rv);  chk("R5 slot addr", rv, 0);
      rd(128 + n, rv); chk("R5 slot ctl", rv, 0);
    end
    // R10 identification bytes
    for (int k = 0; k < 8; k++) begin
      rd(1016 + k, rv); chk("R10 ident", rv, 32'(idb[k]));
    end
    // R11 undefined, word 0, lock
    wr(9, 32'hFFFF_FFFF);
    rd(9, rv); chk("R11 undefined reads zero", rv, 0);
    rd(4, rv); chk("R11 undefined write no effect", rv, 0);
    wr(0, 32'hFFFF_FFFF);
    rd(0, rv); chk("R11 word0 write ignored", rv, 0);
    wr(8, 32'hFFFF_FFFF);
    rd(8, rv); chk("R11 lock bit0 only", rv, 1);
    // R12 hold
    rd(8, rv);
    @(negedge clk); reg_addr = 10'd1017;
    @(negedge clk); chk("R12 hold without strobe", reg_rdata, 1);

    // R1 R2 R3 sweep over all sources
    for (int s = 0; s < 32; s++) begin
      logic [31:0] b;
      b = 32'h1 << s;
      hw_req = b;
      wr(4, b);
      rd(2, rv); chk("R1 raw hw", rv, b);
      rd(0, rv); chk("R1 irq status", rv, b);
      rd(4, rv); chk("R3 enable readback", rv, b);
      chk("R6 idle irq_o", 32'(irq_o), 1);
      chk("R2 fiq_o low", 32'(fiq_o), 0);
      wr(3, b);
      rd(1, rv); chk("R1 fiq status", rv, b);
      rd(0, rv); chk("R1 routed out of irq status", rv, 0);
      chk("R2 fiq_o high", 32'(fiq_o), 1);
      chk("R2 irq_o low when routed", 32'(irq_o), 0);
      wr(5, b);
      rd(4, rv); chk("R3 enable clear", rv, 0);
      chk("R2 fiq_o ignores enable", 32'(fiq_o), 1);
      wr(3, 0);
      rd(3, rv); chk("R3 route readback", rv, 0);
      hw_req = '0;
      wr(6, b);
      rd(2, rv); chk("R1 raw soft", rv, b);
      rd(6, rv); chk("R3 soft readback", rv, b);
      chk("R1 disabled no irq", 32'(irq_o), 0);
      wr(7, b);
      rd(6, rv); chk("R3 soft clear", rv, 0);
    end

    // R4 slot programming: slot n binds source n+8
    for (int n = 0; n < 16; n++) begin
      wr(64 + n, slot_addr(n));
      wr(128 + n, 32'hFFFF_FFC0 | 32'h20 | 32'(n + 8));
    end
    wr(13, DEFA);
    for (int n = 0; n < 16; n++) begin
      rd(64 + n, rv);  chk("R4 slot addr", rv, slot_addr(n));
      rd(128 + n, rv); chk("R4 slot ctl", rv, 32'h20 | 32'(n + 8));
    end
    rd(13, rv); chk("R4 default addr", rv, DEFA);

    // nesting
    wr(4, 32'hFFFF_FFFF);
    hw_req = 32'h1 << 17; settle();
    chk("R6 idle pending", 32'(irq_o), 1);
    rd(12, rv); chk("R7 ack slot9", rv, slot_addr(9));
    chk("R6 same level masked", 32'(irq_o), 0);
    hw_req |= 32'h1 << 11; settle();
    chk("R6 preempt by slot3", 32'(irq_o), 1);
    rd(12, rv); chk("R7 ack slot3", rv, slot_addr(3));
    chk("R6 level3 masked", 32'(irq_o), 0);
    hw_req |= 32'h1 << 20; settle();
    chk("R6 lower slot masked", 32'(irq_o), 0);
    rd(12, rv); chk("R8 nothing higher", rv, DEFA);
    chk("R8 level unchanged", 32'(irq_o), 0);
    wr(12, 32'h1234);
    chk("R9 back to level9", 32'(irq_o), 1);
    hw_req &= ~(32'h1 << 11); settle();
    chk("R6 level9 rest masked", 32'(irq_o), 0);
    wr(12, 0);
    chk("R9 back to idle", 32'(irq_o), 1);
    rd(12, rv); chk("R7 most urgent first", rv, slot_addr(9));
    wr(12, 0);
    hw_req &= ~(32'h1 << 17);
    rd(12, rv); chk("R7 ack slot12", rv, slot_addr(12));
    wr(12, 0);
    hw_req = 32'h1 << 30; settle();
    chk("R6 unvectored at idle", 32'(irq_o), 1);
    rd(12, rv); chk("R7 default level", rv, DEFA);
    chk("R6 level16 masks unvectored", 32'(irq_o), 0);
    hw_req |= 32'h1 << 8; settle();
    chk("R6 slot0 over level16", 32'(irq_o), 1);
    wr(128, 32'h08);
    chk("R6 disabled slot leaves mask", 32'(irq_o), 0);
    wr(128, 32'h28);
    chk("R6 slot re-enabled", 32'(irq_o), 1);
    wr(3, 32'h1 << 8);
    chk("R2 routed source drives fiq", 32'(fiq_o), 1);
    rd(12, rv); chk("R8 routed cannot raise", rv, DEFA);
    wr(3, 0);
    rd(12, rv); chk("R7 ack slot0", rv, slot_addr(0));
    hw_req = 32'hFFFF_FFFF; settle();
    chk("R6 level0 masks all", 32'(irq_o), 0);
    wr(12, 0);
    chk("R9 back to level16", 32'(irq_o), 1);
    hw_req = 32'h1 << 30; settle();
    chk("R6 level16 again", 32'(irq_o), 0);
    wr(12, 0);
    chk("R9 idle again", 32'(irq_o), 1);
    wr(12, 0);
    chk("R9 idle write no effect", 32'(irq_o), 1);
    rd(12, rv); chk("R9 idle unchanged then ack", rv, DEFA);
    wr(12, 0);
    hw_req = '0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule